// File: doc/BRIEF.md
# Snapshot Table Lock Arbiter

A protocol engine keeps two snapshot tables, one for even-numbered and one for odd-numbered communication cycles. It copies each table into shared memory during a short write window near the end of each cycle. The host may need to read a table without the engine overwriting it part way through, so it can take a lock on either table. This block decides when each lock is granted and when each write window may open. It also records whether the stored snapshot is still current.

A write window for a table opens on the pulse that marks the end of the static segment, but only in a cycle whose parity matches that table. It closes when the network idle time of that cycle ends. A lock request made during the table's window is refused and is not remembered, so the host must retry. A lock that is held keeps that table's window shut. Each table's valid flag sets when a window completes with generation enabled. Both valid flags drop on a counter update while generation is disabled, because the stored tables then no longer match the counters.

Top module: `sft_lock_arbiter`

## Requirements
- R1: While `rst` is sampled high, all lock, valid and write-window outputs are 0 after that clock edge.
- R2: A 1 on `lock_trig[i]` (bit 0 = even table, bit 1 = odd table) while table i is unlocked and its window is closed sets `lock_stat[i]` at that clock edge.
- R3: A 1 on `lock_trig[i]` while table i's window is open and the table is unlocked leaves `lock_stat[i]` at 0. The window stays open, and no lock appears after the window closes.
- R4: A 1 on `lock_trig[i]` while `lock_stat[i]` is 1 clears it at that clock edge.
- R5: A `seg_end` pulse sampled with `cyc_odd`=0 opens `wr_win[0]`, and one with `cyc_odd`=1 opens `wr_win[1]`, from that edge on. The window closes at the first edge where `nit_active` is sampled 0 after having been sampled 1 on the previous edge.
- R6: A `cnt_upd` pulse sampled with `gen_en`=0 clears both `tbl_valid` bits. With `gen_en`=1 it leaves them unchanged.
- R7: A table whose lock is held never has its write window open. A `seg_end` for that table's parity is ignored, and the other table is unaffected.
- R8: `tbl_valid[i]` sets at the edge where table i's window closes, if `gen_en` is 1 in that cycle. If `gen_en` is 0, it does not set.
- R9: Triggers on both tables in the same cycle are handled independently, each by R2 and R4.
- R10: If `lock_trig[i]` and a matching `seg_end` arrive in the same cycle for an unlocked table with a closed window, the lock is granted and the window stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_trig | input | 2 | Per-table lock toggle strobe (bit 0 even, bit 1 odd) |
| cyc_odd | input | 1 | Parity of the current communication cycle (1 = odd) |
| seg_end | input | 1 | One-cycle pulse at the end of the static segment |
| nit_active | input | 1 | High during the network idle time |
| gen_en | input | 1 | Table generation enabled |
| cnt_upd | input | 1 | One-cycle pulse when the sync frame counters update |
| lock_stat | output | 2 | Per-table lock held |
| tbl_valid | output | 2 | Per-table snapshot valid |
| wr_win | output | 2 | Per-table write window open, gates the memory copy |

## Verification
The even and odd windows are driven separately, each with generation on and off. This shows that parity selects the right table and that only an enabled completion sets the valid flag. Lock triggers are applied with the window closed, inside the open window, and on the same edge as the `seg_end` pulse. These cases separate a grant, a refused request that leaves no trace after the window, and the lock-over-window priority. Single and paired triggers, given with the lock held and with it free, separate the two tables' toggles. Counter updates with generation on and then off show which case clears the valid flags.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int NUM_TBL = 2;

    typedef enum logic {
        TBL_EVEN = 1'b0,
        TBL_ODD  = 1'b1
    } tbl_id_e;

    typedef struct packed {
        logic lock;
        logic win;
        logic valid;
    } tbl_state_t;

    function automatic logic parity_match(input tbl_id_e id, input logic odd_cycle);
        return (id == TBL_ODD) ? odd_cycle : ~odd_cycle;
    endfunction

endpackage

// File: rtl/sft_lock_cell.sv
module sft_lock_cell (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic win_q,
    output logic lock_q,
    output logic lock_nxt
);

    always_comb begin
        lock_nxt = lock_q;
        if (trig) begin
            if (lock_q)
                lock_nxt = 1'b0;
            else if (!win_q)
                lock_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else
            lock_q <= lock_nxt;
    end

    // R2: a free trigger outside the window grants
    a_r2_grant: assert property (@(posedge clk) disable iff (rst)
        (trig && !lock_q && !win_q) |=> lock_q);

    // R3: a trigger inside the window is refused
    a_r3_refuse: assert property (@(posedge clk) disable iff (rst)
        (trig && !lock_q && win_q) |=> !lock_q);

    // R4: a trigger on a held lock releases it
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (trig && lock_q) |=> !lock_q);

endmodule

// File: rtl/sft_window_cell.sv
module sft_window_cell
    import sft_pkg::*;
#(
    parameter tbl_id_e TBL = TBL_EVEN
) (
    input  logic clk,
    input  logic rst,
    input  logic seg_end,
    input  logic cyc_odd,
    input  logic nit_fall,
    input  logic lock_nxt,
    output logic win_q,
    output logic win_done
);

    logic open_req;

    always_comb begin
        open_req = seg_end && parity_match(TBL, cyc_odd) && !lock_nxt && !win_q;
        win_done = win_q && nit_fall;
    end

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= 1'b0;
        else if (open_req)
            win_q <= 1'b1;
        else if (win_done)
            win_q <= 1'b0;
    end

    // R5: a window never opens without a matching segment-end pulse
    a_r5_open_cause: assert property (@(posedge clk) disable iff (rst)
        (!win_q && !(seg_end && parity_match(TBL, cyc_odd))) |=> !win_q);

endmodule

// File: rtl/sft_valid_cell.sv
module sft_valid_cell (
    input  logic clk,
    input  logic rst,
    input  logic win_done,
    input  logic gen_en,
    input  logic cnt_upd,
    output logic valid_q
);

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (cnt_upd && !gen_en)
            valid_q <= 1'b0;
        else if (win_done && gen_en)
            valid_q <= 1'b1;
    end

    // R6: counter update with generation off invalidates
    a_r6_invalidate: assert property (@(posedge clk) disable iff (rst)
        (cnt_upd && !gen_en) |=> !valid_q);

    // R8: a completion with generation off does not validate
    a_r8_no_set: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !gen_en) |=> !valid_q);

endmodule

// File: rtl/sft_lock_arbiter.sv
module sft_lock_arbiter
    import sft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lock_trig,
    input  logic       cyc_odd,
    input  logic       seg_end,
    input  logic       nit_active,
    input  logic       gen_en,
    input  logic       cnt_upd,
    output logic [1:0] lock_stat,
    output logic [1:0] tbl_valid,
    output logic [1:0] wr_win
);

    logic       nit_d;
    logic       nit_fall;
    tbl_state_t st [NUM_TBL];

    always_ff @(posedge clk) begin
        if (rst)
            nit_d <= 1'b0;
        else
            nit_d <= nit_active;
    end

    assign nit_fall = nit_d && !nit_active;

    for (genvar i = 0; i < NUM_TBL; i++) begin : g_tbl
        logic lock_nxt;
        logic win_done;

        sft_lock_cell u_lock (
            .clk      (clk),
            .rst      (rst),
            .trig     (lock_trig[i]),
            .win_q    (st[i].win),
            .lock_q   (st[i].lock),
            .lock_nxt (lock_nxt)
        );

        sft_window_cell #(
            .TBL (tbl_id_e'(i))
        ) u_win (
            .clk      (clk),
            .rst      (rst),
            .seg_end  (seg_end),
            .cyc_odd  (cyc_odd),
            .nit_fall (nit_fall),
            .lock_nxt (lock_nxt),
            .win_q    (st[i].win),
            .win_done (win_done)
        );

        sft_valid_cell u_valid (
            .clk      (clk),
            .rst      (rst),
            .win_done (win_done),
            .gen_en   (gen_en),
            .cnt_upd  (cnt_upd),
            .valid_q  (st[i].valid)
        );

        assign lock_stat[i] = st[i].lock;
        assign wr_win[i]    = st[i].win;
        assign tbl_valid[i] = st[i].valid;

        // R7: lock and write window of one table never overlap
        a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(lock_stat[i] && wr_win[i]));
    end

    // R1: reset clears every output
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (lock_stat == 2'b00 && tbl_valid == 2'b00 && wr_win == 2'b00));

endmodule

// File: tb/sft_lock_arbiter_tb.sv
module sft_lock_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] lock_trig;
    logic       cyc_odd;
    logic       seg_end;
    logic       nit_active;
    logic       gen_en;
    logic       cnt_upd;
    logic [1:0] lock_stat;
    logic [1:0] tbl_valid;
    logic [1:0] wr_win;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sft_lock_arbiter u_dut (
        .clk        (clk),
        .rst        (rst),
        .lock_trig  (lock_trig),
        .cyc_odd    (cyc_odd),
        .seg_end    (seg_end),
        .nit_active (nit_active),
        .gen_en     (gen_en),
        .cnt_upd    (cnt_upd),
        .lock_stat  (lock_stat),
        .tbl_valid  (tbl_valid),
        .wr_win     (wr_win)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // opens a window of the given parity: one edge with seg_end
    task automatic pulse_seg(input logic odd);
        cyc_odd = odd;
        seg_end = 1'b1;
        tick();
        seg_end = 1'b0;
    endtask

    // network idle time: high for two edges, then the falling edge closes
    task automatic run_nit();
        tick();
        nit_active = 1'b1;
        tick();
        tick();
        nit_active = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 lock", lock_stat, 2'b00);
        chk("R1 valid", tbl_valid, 2'b00);
        chk("R1 window", wr_win, 2'b00);
    endtask

    task automatic t_windows();
        gen_en = 1'b1;
        pulse_seg(1'b0);
        chk("R5 even window open", wr_win, 2'b01);
        run_nit();
        chk("R5 even window closed", wr_win, 2'b00);
        chk("R8 even valid", tbl_valid, 2'b01);
        pulse_seg(1'b1);
        chk("R5 odd window open", wr_win, 2'b10);
        run_nit();
        chk("R5 odd window closed", wr_win, 2'b00);
        chk("R8 odd valid", tbl_valid, 2'b11);
    endtask

    task automatic t_valid_clear();
        gen_en  = 1'b1;
        cnt_upd = 1'b1;
        tick();
        cnt_upd = 1'b0;
        chk("R6 update with gen on keeps", tbl_valid, 2'b11);
        gen_en  = 1'b0;
        cnt_upd = 1'b1;
        tick();
        cnt_upd = 1'b0;
        chk("R6 update with gen off clears", tbl_valid, 2'b00);
        pulse_seg(1'b0);
        run_nit();
        chk("R8 no valid with gen off", tbl_valid, 2'b00);
        gen_en = 1'b1;
    endtask

    task automatic t_grant_release();
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
        chk("R2 grant even", lock_stat, 2'b01);
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
        chk("R4 release even", lock_stat, 2'b00);
    endtask

    task automatic t_refuse();
        pulse_seg(1'b1);
        lock_trig = 2'b10;
        tick();
        lock_trig = 2'b00;
        chk("R3 refused in window", lock_stat, 2'b00);
        chk("R3 window stays open", wr_win, 2'b10);
        run_nit();
        chk("R3 no remembered request", lock_stat, 2'b00);
    endtask

    task automatic t_suppress();
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
        pulse_seg(1'b0);
        chk("R7 locked even window shut", wr_win, 2'b00);
        run_nit();
        pulse_seg(1'b1);
        chk("R7 odd window unaffected", wr_win, 2'b10);
        run_nit();
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
        chk("R7 cleanup unlock", lock_stat, 2'b00);
    endtask

    task automatic t_simul();
        lock_trig = 2'b11;
        tick();
        chk("R9 both grant", lock_stat, 2'b11);
        lock_trig = 2'b01;
        tick();
        chk("R9 even only released", lock_stat, 2'b10);
        lock_trig = 2'b11;
        tick();
        lock_trig = 2'b00;
        chk("R9 mixed grant and release", lock_stat, 2'b01);
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
    endtask

    task automatic t_coincide();
        lock_trig = 2'b01;
        pulse_seg(1'b0);
        lock_trig = 2'b00;
        chk("R10 lock wins", lock_stat, 2'b01);
        chk("R10 window stays shut", wr_win, 2'b00);
        run_nit();
        lock_trig = 2'b01;
        tick();
        lock_trig = 2'b00;
    endtask

    initial begin
        rst = 1'b1; lock_trig = 2'b00; cyc_odd = 1'b0; seg_end = 1'b0;
        nit_active = 1'b0; gen_en = 1'b0; cnt_upd = 1'b0;
        tick();
        tick();
        t_reset();
        rst = 1'b0;
        t_windows();
        t_valid_clear();
        t_grant_release();
        t_refuse();
        t_suppress();
        t_simul();
        t_coincide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule